// File: doc/BRIEF.md
# Operand Effective Address Decoder

This block turns the 6-bit operand field of a 16-bit stack-machine instruction into everything the execute stage needs to touch that operand. It reports what kind of operand it is: a general register, a memory word, the stack pointer, the program counter, the overflow register or a literal. It also gives the operand's value when that value is known without a memory read, the effective memory address when there is one, and the updated stack pointer and program counter that the operand's addressing mode implies. A flag marks literal operands, whose writes the execute stage must throw away. A second flag marks every operand that touches memory, so that a watchpoint or access-accounting unit can observe the access together with its address.

The caller presents the operand code, the eight general registers as one flat vector, the stack pointer, the program counter, the overflow register and the word that follows the instruction, with `valid_i` high. One clock later every result is registered on the outputs and `valid_o` is high. While `valid_i` is low, the outputs keep their last values. The register file, the memory and the fetch of the next word are outside this block.

Top module: `opd_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operand, `valid_o`, `kind_o`, `value_o`, `addr_o`, `ram_ev_o`, `literal_o`, `nw_used_o`, `sp_next_o` and `pc_next_o` are all zero.
- R2: Codes 0x00–0x07 give kind 0 (register). `value_o` is register `code[2:0]`, where register k is `regs_i[16k+15:16k]` and the order for k = 0..7 is A, B, C, X, Y, Z, I, J.
- R3: Codes 0x08–0x0F give kind 1 (memory) with `addr_o` equal to register `code[2:0]`. They do not consume the next word.
- R4: Codes 0x10–0x17 give kind 1 with `addr_o` = `nxt_i` + register `code[2:0]` modulo 2^16. They set `nw_used_o` and make `pc_next_o` = `pc_i` + 1 modulo 2^16.
- R5: Code 0x18 (pop) gives kind 1 with `addr_o` = `sp_i` and `sp_next_o` = `sp_i` + 1 modulo 2^16.
- R6: Code 0x19 (peek) gives kind 1 with `addr_o` = `sp_i` and `sp_next_o` = `sp_i`.
- R7: Code 0x1A (push) gives kind 1 with `sp_next_o` = `sp_i` − 1 modulo 2^16 and `addr_o` equal to that decremented value.
- R8: Codes 0x1B, 0x1C and 0x1D give kinds 2, 3 and 4. `value_o` is `sp_i`, `pc_i` and `ex_i` respectively.
- R9: Code 0x1E gives kind 1 with `addr_o` = `nxt_i`. It sets `nw_used_o` and makes `pc_next_o` = `pc_i` + 1.
- R10: Code 0x1F gives kind 5 (literal) with `value_o` = `nxt_i`. It sets `nw_used_o` and makes `pc_next_o` = `pc_i` + 1.
- R11: Codes 0x20–0x3F give kind 5 with `value_o` = code − 0x20. They leave `pc_next_o` = `pc_i`.
- R12: `literal_o` is 1 exactly for codes 0x1F and above. `ram_ev_o` is 1 exactly when the kind is 1. `addr_o` is 0 for every kind other than 1, and `value_o` is 0 for kind 1.
- R13: Results appear one clock after an edge with `valid_i` high, and `valid_o` is high in that cycle. After an edge with `valid_i` low, `valid_o` is 0 and all other outputs keep their previous values.
- R14: Only codes 0x18 and 0x1A change `sp_next_o` from `sp_i`. Only codes 0x10–0x17, 0x1E and 0x1F change `pc_next_o` from `pc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operand code and context are presented this cycle |
| code_i | input | 6 | Operand code |
| regs_i | input | 128 | Eight general registers, register k in bits 16k+15:16k |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | Program counter, pointing at the word after the instruction |
| ex_i | input | 16 | Overflow register |
| nxt_i | input | 16 | Word at `pc_i`, fetched ahead |
| valid_o | output | 1 | Registered results belong to an accepted operand |
| kind_o | output | 3 | 0 register, 1 memory, 2 SP, 3 PC, 4 overflow, 5 literal |
| value_o | output | 16 | Operand value for non-memory kinds |
| addr_o | output | 16 | Effective address for memory kind |
| ram_ev_o | output | 1 | Memory access event |
| literal_o | output | 1 | Operand is a literal; writes to it are discarded |
| nw_used_o | output | 1 | The next word was consumed |
| sp_next_o | output | 16 | Stack pointer after the operand's side effect |
| pc_next_o | output | 16 | Program counter after the operand's side effect |

## Verification
All 64 codes are swept under three register and pointer contexts, with every output compared against values worked out in the bench. The contexts place the stack pointer at 0x0000 and at 0xFFFF, so a push or pop that forgets to wrap, or that applies the decrement after the access instead of before it, shows up as a wrong address or stack pointer. The indexed mode is given a next word and register that overflow 16 bits, and the program counter sits at 0xFFFF in one context, to catch adders that are too wide or that miss the wrap. The boundaries at 0x1E/0x1F and 0x1F/0x20 catch an off-by-one in the literal flag or in the short-literal offset. A pause with `valid_i` low and changed inputs catches outputs that fail to hold.

// File: rtl/opd_pkg.sv
package opd_pkg;

    localparam int OPD_CODE_W = 6;
    localparam int OPD_NREG   = 8;
    localparam int OPD_IDX_W  = $clog2(OPD_NREG);
    localparam int OPD_SLIT_W = OPD_CODE_W - 1;

    typedef enum logic [2:0] {
        K_REG = 3'd0,
        K_MEM = 3'd1,
        K_SP  = 3'd2,
        K_PC  = 3'd3,
        K_EX  = 3'd4,
        K_LIT = 3'd5
    } opd_kind_e;

    typedef enum logic [3:0] {
        M_REG,
        M_IND,
        M_IDX,
        M_POP,
        M_PEEK,
        M_PUSH,
        M_SP,
        M_PC,
        M_EX,
        M_NWIND,
        M_NWLIT,
        M_SLIT
    } opd_mode_e;

endpackage

// File: rtl/opd_classify.sv
module opd_classify
    import opd_pkg::*;
(
    input  logic [OPD_CODE_W-1:0] code_i,
    output opd_mode_e             mode_o,
    output opd_kind_e             kind_o,
    output logic [OPD_IDX_W-1:0]  idx_o,
    output logic                  nw_o,
    output logic                  lit_o
);

    always_comb begin
        idx_o  = code_i[OPD_IDX_W-1:0];
        mode_o = M_SLIT;
        if (code_i[OPD_CODE_W-1] == 1'b0) begin
            case (code_i[4:3])
                2'd0: mode_o = M_REG;
                2'd1: mode_o = M_IND;
                2'd2: mode_o = M_IDX;
                default: begin
                    case (code_i[2:0])
                        3'd0: mode_o = M_POP;
                        3'd1: mode_o = M_PEEK;
                        3'd2: mode_o = M_PUSH;
                        3'd3: mode_o = M_SP;
                        3'd4: mode_o = M_PC;
                        3'd5: mode_o = M_EX;
                        3'd6: mode_o = M_NWIND;
                        default: mode_o = M_NWLIT;
                    endcase
                end
            endcase
        end
    end

    always_comb begin
        kind_o = K_MEM;
        nw_o   = 1'b0;
        lit_o  = 1'b0;
        case (mode_o)
            M_REG:   kind_o = K_REG;
            M_SP:    kind_o = K_SP;
            M_PC:    kind_o = K_PC;
            M_EX:    kind_o = K_EX;
            M_IDX,
            M_NWIND: nw_o   = 1'b1;
            M_NWLIT: begin
                kind_o = K_LIT;
                nw_o   = 1'b1;
                lit_o  = 1'b1;
            end
            M_SLIT: begin
                kind_o = K_LIT;
                lit_o  = 1'b1;
            end
            default: kind_o = K_MEM;
        endcase
    end

endmodule

// File: rtl/opd_regsel.sv
module opd_regsel
    import opd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OPD_NREG*W-1:0] regs_i,
    input  logic [OPD_IDX_W-1:0]  idx_i,
    output logic [W-1:0]          sel_o
);

    logic [W-1:0] bank [OPD_NREG];

    for (genvar g = 0; g < OPD_NREG; g++) begin : g_unpack
        assign bank[g] = regs_i[g*W +: W];
    end

    assign sel_o = bank[idx_i];

endmodule

// File: rtl/opd_effaddr.sv
module opd_effaddr
    import opd_pkg::*;
#(
    parameter int W = 16
) (
    input  opd_mode_e    mode_i,
    input  logic [W-1:0] reg_i,
    input  logic [W-1:0] sp_i,
    input  logic [W-1:0] nxt_i,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] sp_next_o,
    output logic         ram_ev_o
);

    logic [W-1:0] sp_inc;
    logic [W-1:0] sp_dec;
    logic [W-1:0] idx_sum;

    assign sp_inc  = sp_i + W'(1);
    assign sp_dec  = sp_i - W'(1);
    assign idx_sum = nxt_i + reg_i;

    always_comb begin
        addr_o    = '0;
        sp_next_o = sp_i;
        ram_ev_o  = 1'b1;
        case (mode_i)
            M_IND:   addr_o = reg_i;
            M_IDX:   addr_o = idx_sum;
            M_POP: begin
                addr_o    = sp_i;
                sp_next_o = sp_inc;
            end
            M_PEEK:  addr_o = sp_i;
            M_PUSH: begin
                addr_o    = sp_dec;
                sp_next_o = sp_dec;
            end
            M_NWIND: addr_o = nxt_i;
            default: ram_ev_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/opd_decoder.sv
module opd_decoder
    import opd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic [OPD_CODE_W-1:0] code_i,
    input  logic [OPD_NREG*W-1:0] regs_i,
    input  logic [W-1:0]          sp_i,
    input  logic [W-1:0]          pc_i,
    input  logic [W-1:0]          ex_i,
    input  logic [W-1:0]          nxt_i,
    output logic                  valid_o,
    output logic [2:0]            kind_o,
    output logic [W-1:0]          value_o,
    output logic [W-1:0]          addr_o,
    output logic                  ram_ev_o,
    output logic                  literal_o,
    output logic                  nw_used_o,
    output logic [W-1:0]          sp_next_o,
    output logic [W-1:0]          pc_next_o
);

    typedef struct packed {
        logic         valid;
        opd_kind_e    kind;
        logic [W-1:0] value;
        logic [W-1:0] addr;
        logic         ram_ev;
        logic         lit;
        logic         nw;
        logic [W-1:0] sp_nx;
        logic [W-1:0] pc_nx;
    } res_t;

    opd_mode_e             mode;
    opd_kind_e             kind;
    logic [OPD_IDX_W-1:0]  idx;
    logic                  nw;
    logic                  lit;
    logic [W-1:0]          reg_val;
    logic [W-1:0]          ea;
    logic [W-1:0]          sp_nx;
    logic                  ram_ev;
    logic [W-1:0]          opd_val;
    res_t                  res_d;
    res_t                  res_q;

    opd_classify u_cls (
        .code_i (code_i),
        .mode_o (mode),
        .kind_o (kind),
        .idx_o  (idx),
        .nw_o   (nw),
        .lit_o  (lit)
    );

    opd_regsel #(.W(W)) u_rsel (
        .regs_i (regs_i),
        .idx_i  (idx),
        .sel_o  (reg_val)
    );

    opd_effaddr #(.W(W)) u_ea (
        .mode_i    (mode),
        .reg_i     (reg_val),
        .sp_i      (sp_i),
        .nxt_i     (nxt_i),
        .addr_o    (ea),
        .sp_next_o (sp_nx),
        .ram_ev_o  (ram_ev)
    );

    always_comb begin
        case (mode)
            M_REG:   opd_val = reg_val;
            M_SP:    opd_val = sp_i;
            M_PC:    opd_val = pc_i;
            M_EX:    opd_val = ex_i;
            M_NWLIT: opd_val = nxt_i;
            M_SLIT:  opd_val = {{(W-OPD_SLIT_W){1'b0}}, code_i[OPD_SLIT_W-1:0]};
            default: opd_val = '0;
        endcase
    end

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (valid_i) begin
            res_d.valid  = 1'b1;
            res_d.kind   = kind;
            res_d.value  = opd_val;
            res_d.addr   = ea;
            res_d.ram_ev = ram_ev;
            res_d.lit    = lit;
            res_d.nw     = nw;
            res_d.sp_nx  = sp_nx;
            res_d.pc_nx  = nw ? pc_i + W'(1) : pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign valid_o   = res_q.valid;
    assign kind_o    = res_q.kind;
    assign value_o   = res_q.value;
    assign addr_o    = res_q.addr;
    assign ram_ev_o  = res_q.ram_ev;
    assign literal_o = res_q.lit;
    assign nw_used_o = res_q.nw;
    assign sp_next_o = res_q.sp_nx;
    assign pc_next_o = res_q.pc_nx;

endmodule

// File: rtl/opd_decoder_chk.sv
module opd_decoder_chk
    import opd_pkg::*;
#(
    parameter int W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  valid_i,
    input logic [OPD_CODE_W-1:0] code_i,
    input logic [W-1:0]          sp_i,
    input logic [W-1:0]          pc_i,
    input logic                  valid_o,
    input logic [2:0]            kind_o,
    input logic [W-1:0]          addr_o,
    input logic                  ram_ev_o,
    input logic                  literal_o,
    input logic                  nw_used_o,
    input logic [W-1:0]          sp_next_o,
    input logic [W-1:0]          pc_next_o
);

    // R12
    lit_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && literal_o |-> !ram_ev_o && kind_o == K_LIT);

    // R12
    ram_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ram_ev_o == (kind_o == K_MEM));

    // R14
    sp_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && kind_o != K_MEM |-> sp_next_o == $past(sp_i));

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && nw_used_o |-> pc_next_o == W'($past(pc_i) + W'(1)));

    // R14
    pc_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !nw_used_o |-> pc_next_o == $past(pc_i));

    // R5
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && $past(code_i) == 6'h18 |-> sp_next_o == W'($past(sp_i) + W'(1)) && addr_o == $past(sp_i));

    // R7
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && $past(code_i) == 6'h1A |-> addr_o == sp_next_o && sp_next_o == W'($past(sp_i) - W'(1)));

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o && $stable(addr_o) && $stable(sp_next_o) && $stable(pc_next_o));

endmodule

bind opd_decoder opd_decoder_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .code_i    (code_i),
    .sp_i      (sp_i),
    .pc_i      (pc_i),
    .valid_o   (valid_o),
    .kind_o    (kind_o),
    .addr_o    (addr_o),
    .ram_ev_o  (ram_ev_o),
    .literal_o (literal_o),
    .nw_used_o (nw_used_o),
    .sp_next_o (sp_next_o),
    .pc_next_o (pc_next_o)
);

// File: tb/opd_decoder_tb.sv
module opd_decoder_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [5:0]   code_i = '0;
    logic [127:0] regs_i = '0;
    logic [15:0]  sp_i = '0, pc_i = '0, ex_i = '0, nxt_i = '0;
    logic         valid_o, ram_ev_o, literal_o, nw_used_o;
    logic [2:0]   kind_o;
    logic [15:0]  value_o, addr_o, sp_next_o, pc_next_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    opd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .code_i(code_i),
        .regs_i(regs_i), .sp_i(sp_i), .pc_i(pc_i), .ex_i(ex_i), .nxt_i(nxt_i),
        .valid_o(valid_o), .kind_o(kind_o), .value_o(value_o), .addr_o(addr_o),
        .ram_ev_o(ram_ev_o), .literal_o(literal_o), .nw_used_o(nw_used_o),
        .sp_next_o(sp_next_o), .pc_next_o(pc_next_o)
    );

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s code=%h got %h expected %h", req, what, code_i, got, exp);
        end
    endtask

    function automatic logic [15:0] rv(input int p, input int k);
        case (p)
            0: rv = 16'h1000 + 16'(k * 16'h0111);
            1: rv = 16'hFFFF - 16'(k);
            default: rv = 16'((k << 12) | 16'h00F0);
        endcase
    endfunction

    task automatic set_ctx(input int p);
        for (int k = 0; k < 8; k++) regs_i[k*16 +: 16] = rv(p, k);
        case (p)
            0: begin sp_i = 16'h0000; pc_i = 16'hFFFF; ex_i = 16'h00A5; nxt_i = 16'hF800; end
            1: begin sp_i = 16'hFFFF; pc_i = 16'h1234; ex_i = 16'hFFFF; nxt_i = 16'h0003; end
            default: begin sp_i = 16'h8000; pc_i = 16'h0000; ex_i = 16'h0000; nxt_i = 16'h7FFF; end
        endcase
    endtask

    task automatic check_vec(input int p, input int c);
        logic [15:0] r, ev, ea, esp, epc;
        logic [2:0]  ek;
        logic        eram, elit, enw;
        string       tag;
        r = rv(p, c % 8);
        ek = 3'd0; ev = '0; ea = '0; eram = 1'b0; elit = 1'b0; enw = 1'b0;
        esp = sp_i; epc = pc_i; tag = "R2";
        if (c < 8) begin
            ev = r; tag = "R2";
        end else if (c < 16) begin
            ek = 3'd1; ea = r; eram = 1'b1; tag = "R3";
        end else if (c < 24) begin
            ek = 3'd1; ea = nxt_i + r; eram = 1'b1; enw = 1'b1; epc = pc_i + 16'd1; tag = "R4";
        end else if (c >= 32) begin
            ek = 3'd5; ev = 16'(c - 32); elit = 1'b1; tag = "R11";
        end else begin
            case (c)
                24: begin ek = 3'd1; ea = sp_i; esp = sp_i + 16'd1; eram = 1'b1; tag = "R5"; end
                25: begin ek = 3'd1; ea = sp_i; eram = 1'b1; tag = "R6"; end
                26: begin ek = 3'd1; esp = sp_i - 16'd1; ea = esp; eram = 1'b1; tag = "R7"; end
                27: begin ek = 3'd2; ev = sp_i; tag = "R8"; end
                28: begin ek = 3'd3; ev = pc_i; tag = "R8"; end
                29: begin ek = 3'd4; ev = ex_i; tag = "R8"; end
                30: begin ek = 3'd1; ea = nxt_i; eram = 1'b1; enw = 1'b1; epc = pc_i + 16'd1; tag = "R9"; end
                default: begin ek = 3'd5; ev = nxt_i; elit = 1'b1; enw = 1'b1; epc = pc_i + 16'd1; tag = "R10"; end
            endcase
        end
        chk("R13", "valid", 16'(valid_o), 16'd1);
        chk(tag, "kind", 16'(kind_o), 16'(ek));
        chk(tag, "value", value_o, ev);
        chk(tag, "addr", addr_o, ea);
        chk("R12", "ram_ev", 16'(ram_ev_o), 16'(eram));
        chk("R12", "literal", 16'(literal_o), 16'(elit));
        chk(tag, "nw_used", 16'(nw_used_o), 16'(enw));
        chk((c == 24 || c == 26) ? tag : "R14", "sp_next", sp_next_o, esp);
        chk(enw ? tag : "R14", "pc_next", pc_next_o, epc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] h_addr, h_val, h_sp, h_pc;
        logic [2:0]  h_kind;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "valid", 16'(valid_o), 16'd0);
        chk("R1", "kind", 16'(kind_o), 16'd0);
        chk("R1", "value|addr", value_o | addr_o, 16'd0);
        chk("R1", "flags", 16'({ram_ev_o, literal_o, nw_used_o}), 16'd0);
        chk("R1", "sp|pc", sp_next_o | pc_next_o, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after release", 16'(valid_o), 16'd0);
        for (int p = 0; p < 3; p++) begin
            set_ctx(p);
            for (int c = 0; c < 64; c++) begin
                code_i = 6'(c);
                valid_i = 1'b1;
                @(negedge clk);
                check_vec(p, c);
                if (c == 26) begin
                    // R13: idle cycle with changed inputs must hold the result
                    h_addr = addr_o; h_val = value_o; h_sp = sp_next_o; h_pc = pc_next_o; h_kind = kind_o;
                    valid_i = 1'b0;
                    code_i = 6'h1F;
                    sp_i = sp_i ^ 16'h5A5A;
                    pc_i = pc_i ^ 16'h0F0F;
                    @(negedge clk);
                    chk("R13", "valid idle", 16'(valid_o), 16'd0);
                    chk("R13", "addr hold", addr_o, h_addr);
                    chk("R13", "value hold", value_o, h_val);
                    chk("R13", "sp hold", sp_next_o, h_sp);
                    chk("R13", "pc hold", pc_next_o, h_pc);
                    chk("R13", "kind hold", 16'(kind_o), 16'(h_kind));
                    set_ctx(p);
                end
            end
        end
        valid_i = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule